// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit descriptors kept in an on-block descriptor memory. Each descriptor takes two 32-bit words: a status/control word and a buffer address word. The engine looks at one descriptor at a time. When the host marks that descriptor ready, the engine hands a frame request to a downstream transmitter. The request carries the length, the buffer address, and the pad and CRC flags. The engine then waits for the transmitter to report completion.

On completion, the engine writes the per-frame result into the descriptor and then hands the descriptor back to the host by clearing its ready bit. If the descriptor asked for it, the engine also raises a frame-done or frame-error interrupt source. The host reaches the descriptor memory and three control registers (interrupt source, interrupt mask, ring length) through a simple synchronous word bus. Reads return one cycle after the request.

The transmitter itself, the reads of buffer memory and any receive ring are outside this block.

Top module: `eth_txring`

## Requirements
- R1: After reset the interrupt source, interrupt mask and ring length registers read 0, and no frame request is issued.
- R2: A write to the ring length register (byte offset 0x20) stores the written value, limited to at most DESC_NUM (128 by default). Reading back returns the stored value.
- R3: Descriptor i occupies byte offsets 0x400+8i (status word) and 0x404+8i (buffer address). The host can write and read back both words. A host write to this memory in the same cycle as an engine write goes first, and the engine's write is delayed rather than lost.
- R4: In the status word, bits 31:16 are the length, bit 15 ready, bit 14 interrupt enable, bit 13 wrap, bit 12 pad and bit 11 CRC enable. A request is issued only for a descriptor whose ready bit is set. While the current descriptor is not ready, the engine keeps polling it and does not advance.
- R5: A request presents the descriptor's length, its buffer address and its CRC bit. The pad flag is raised only when the pad bit is set and the length is below 64. All request fields stay stable until the transmitter acknowledges.
- R6: At completion, status bits 8:0 are replaced by the reported result: carrier lost in bit 0, deferred in bit 1, late collision in bit 2, retry limit in bit 3, retry count in bits 7:4 and underrun in bit 8. All other bits are kept. The ready bit is cleared only in a later write, after that result is stored.
- R7: After descriptor i completes, the engine moves to descriptor i+1. It moves to descriptor 0 instead when the wrap bit of descriptor i is set, or when i equals the ring length minus one.
- R8: The interrupt source register (offset 0x04) has frame-done at bit 0 and frame-error at bit 1. A completion sets bit 1 when any of result bits 0, 2, 3 or 8 is set, and sets bit 0 otherwise. It sets neither bit when the descriptor's interrupt-enable bit is clear. Writing 1 to a bit clears it, and a set bit stays set until it is cleared.
- R9: The interrupt mask register (offset 0x08) holds two bits. The irq output is high exactly when some source bit and its mask bit are both set.
- R10: With a ring length of 0 the engine issues no requests, even for a ready descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 12 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after a read |
| irq | output | 1 | Masked interrupt request |
| frm_req | output | 1 | Frame request valid |
| frm_ack | input | 1 | Transmitter accepts the request |
| frm_len | output | 16 | Frame length |
| frm_addr | output | 32 | Buffer address |
| frm_pad | output | 1 | Pad the frame to minimum size |
| frm_crc | output | 1 | Append CRC |
| done_vld | input | 1 | Transmitter completion pulse |
| done_stat | input | 9 | Completion result bits |

## Verification
Several properties are checked on every cycle by the assertions:
- a pending request holds its fields until acknowledged;
- a request is only made for a descriptor captured as ready;
- the ready-clearing write always follows a result write-back;
- the two interrupt sources are never set together;
- source bits stay set until cleared;
- the ring length never exceeds its cap;
- host and engine never write the memory in the same cycle.

The bench scenarios are needed to show the rest:
- the exact values written back into a descriptor;
- the walk order, including early wrap and the end-of-ring turn;
- the pad rule for short frames;
- the error versus frame-done choice, and its suppression when interrupts are disabled;
- masking of the irq output;
- idle behaviour with a zero ring length or a descriptor that is not ready.

// File: rtl/eth_txring_pkg.sv
package eth_txring_pkg;
    localparam int STAT_RDY  = 15;
    localparam int STAT_IRQ  = 14;
    localparam int STAT_WRAP = 13;
    localparam int STAT_PAD  = 12;
    localparam int STAT_CRC  = 11;
    localparam int RES_W     = 9;

    // result bits that count as a failed transmission
    localparam logic [RES_W-1:0] RES_ERR_MASK = 9'h10D;

    localparam int OFS_SRC  = 'h04;
    localparam int OFS_MASK = 'h08;
    localparam int OFS_LEN  = 'h20;
    localparam int OFS_RING = 'h400;

    typedef enum logic [2:0] {
        ST_POLL,
        ST_REQ,
        ST_WAIT,
        ST_WB,
        ST_CLR
    } ring_st_e;
endpackage

// File: rtl/txring_desc_ram.sv
module txring_desc_ram #(
    parameter int DESC_NUM = 128,
    localparam int WORDS   = 2 * DESC_NUM,
    localparam int WI_W    = $clog2(WORDS),
    localparam int IDX_W   = $clog2(DESC_NUM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [WI_W-1:0]  host_idx,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rdata,
    input  logic             eng_we,
    input  logic [WI_W-1:0]  eng_widx,
    input  logic [31:0]      eng_wdata,
    input  logic [IDX_W-1:0] eng_desc,
    output logic [31:0]      eng_stat,
    output logic [31:0]      eng_addr
);
    logic [31:0] mem_q [WORDS];

    assign host_rdata = mem_q[host_idx];
    assign eng_stat   = mem_q[{eng_desc, 1'b0}];
    assign eng_addr   = mem_q[{eng_desc, 1'b1}];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
        end else if (host_we) begin
            mem_q[host_idx] <= host_wdata;
        end else if (eng_we) begin
            mem_q[eng_widx] <= eng_wdata;
        end
    end

    // R3
    no_wr_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_we && eng_we));
endmodule

// File: rtl/txring_regs.sv
module txring_regs
    import eth_txring_pkg::*;
#(
    parameter int DESC_NUM = 128,
    parameter int ADDR_W   = 12,
    localparam int WI_W    = $clog2(2 * DESC_NUM),
    localparam int CNT_W   = $clog2(DESC_NUM + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic [31:0]       ram_rdata,
    output logic              ram_we,
    output logic [WI_W-1:0]   ram_idx,
    input  logic              set_txf,
    input  logic              set_txe,
    output logic [CNT_W-1:0]  ring_len,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] RING_LO = ADDR_W'(OFS_RING);
    localparam logic [ADDR_W-1:0] RING_HI = ADDR_W'(OFS_RING + 8 * DESC_NUM);

    typedef struct packed {
        logic [1:0]       src;
        logic [1:0]       mask;
        logic [CNT_W-1:0] len;
        logic [31:0]      rdata;
    } regs_t;

    regs_t reg_d, reg_q;
    logic  in_ring, wr_src, wr_mask, wr_len, rd_any;
    logic [1:0] src_set, src_clr;

    always_comb begin
        in_ring = (host_addr >= RING_LO) && (host_addr < RING_HI);
        ram_idx = WI_W'((host_addr - RING_LO) >> 2);
        ram_we  = host_sel && host_we && in_ring;
        wr_src  = host_sel && host_we && (host_addr == ADDR_W'(OFS_SRC));
        wr_mask = host_sel && host_we && (host_addr == ADDR_W'(OFS_MASK));
        wr_len  = host_sel && host_we && (host_addr == ADDR_W'(OFS_LEN));
        rd_any  = host_sel && !host_we;
        src_set = {set_txe, set_txf};
        src_clr = wr_src ? host_wdata[1:0] : 2'b00;

        reg_d = reg_q;
        // a new event wins over a simultaneous clear
        reg_d.src = src_set | (reg_q.src & ~src_clr);
        if (wr_mask) reg_d.mask = host_wdata[1:0];
        if (wr_len) begin
            if (host_wdata > 32'(DESC_NUM)) reg_d.len = CNT_W'(DESC_NUM);
            else                            reg_d.len = host_wdata[CNT_W-1:0];
        end
        if (rd_any) begin
            if (in_ring)                               reg_d.rdata = ram_rdata;
            else if (host_addr == ADDR_W'(OFS_SRC))    reg_d.rdata = {30'b0, reg_q.src};
            else if (host_addr == ADDR_W'(OFS_MASK))   reg_d.rdata = {30'b0, reg_q.mask};
            else if (host_addr == ADDR_W'(OFS_LEN))    reg_d.rdata = 32'(reg_q.len);
            else                                       reg_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign host_rdata = reg_q.rdata;
    assign ring_len   = reg_q.len;
    assign irq        = |(reg_q.src & reg_q.mask);

    // R8
    src_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q.src[0] && !(wr_src && host_wdata[0])) |=> reg_q.src[0]);
    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q.src[1] && !(wr_src && host_wdata[1])) |=> reg_q.src[1]);
    // R2
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_q.len <= CNT_W'(DESC_NUM));
endmodule

// File: rtl/txring_ctrl.sv
module txring_ctrl
    import eth_txring_pkg::*;
#(
    parameter int DESC_NUM  = 128,
    parameter int LEN_W     = 16,
    parameter int MIN_FRAME = 64,
    localparam int IDX_W    = $clog2(DESC_NUM),
    localparam int WI_W     = IDX_W + 1,
    localparam int CNT_W    = $clog2(DESC_NUM + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ring_len,
    input  logic             host_ram_we,
    input  logic [31:0]      cur_stat,
    input  logic [31:0]      cur_addr,
    output logic [IDX_W-1:0] desc_idx,
    output logic             eng_we,
    output logic [WI_W-1:0]  eng_widx,
    output logic [31:0]      eng_wdata,
    output logic             frm_req,
    input  logic             frm_ack,
    output logic [LEN_W-1:0] frm_len,
    output logic [31:0]      frm_addr,
    output logic             frm_pad,
    output logic             frm_crc,
    input  logic             done_vld,
    input  logic [RES_W-1:0] done_stat,
    output logic             set_txf,
    output logic             set_txe
);
    typedef struct packed {
        ring_st_e         st;
        logic [IDX_W-1:0] idx;
        logic [31:0]      stat;
        logic [31:0]      addr;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  last_desc, has_err;

    always_comb begin
        ctl_d     = ctl_q;
        eng_we    = 1'b0;
        eng_wdata = '0;
        set_txf   = 1'b0;
        set_txe   = 1'b0;
        last_desc = (CNT_W'(ctl_q.idx) == ring_len - CNT_W'(1)) || ctl_q.stat[STAT_WRAP];
        has_err   = |(ctl_q.stat[RES_W-1:0] & RES_ERR_MASK);

        unique case (ctl_q.st)
            ST_POLL: begin
                if (ring_len != '0) begin
                    if (CNT_W'(ctl_q.idx) >= ring_len) begin
                        ctl_d.idx = '0;
                    end else if (!host_ram_we && cur_stat[STAT_RDY]) begin
                        ctl_d.stat = cur_stat;
                        ctl_d.addr = cur_addr;
                        ctl_d.st   = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (frm_ack) ctl_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (done_vld) begin
                    ctl_d.stat[RES_W-1:0] = done_stat;
                    ctl_d.st              = ST_WB;
                end
            end
            ST_WB: begin
                if (!host_ram_we) begin
                    eng_we    = 1'b1;
                    eng_wdata = ctl_q.stat;
                    ctl_d.st  = ST_CLR;
                end
            end
            ST_CLR: begin
                if (!host_ram_we) begin
                    eng_we                = 1'b1;
                    eng_wdata             = ctl_q.stat;
                    eng_wdata[STAT_RDY]   = 1'b0;
                    ctl_d.stat[STAT_RDY]  = 1'b0;
                    if (ctl_q.stat[STAT_IRQ]) begin
                        set_txe = has_err;
                        set_txf = !has_err;
                    end
                    ctl_d.idx = last_desc ? '0 : ctl_q.idx + 1'b1;
                    ctl_d.st  = ST_POLL;
                end
            end
            default: ctl_d.st = ST_POLL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_POLL;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign desc_idx = ctl_q.idx;
    assign eng_widx = {ctl_q.idx, 1'b0};
    assign frm_req  = (ctl_q.st == ST_REQ);
    assign frm_len  = ctl_q.stat[31:16];
    assign frm_addr = ctl_q.addr;
    assign frm_crc  = ctl_q.stat[STAT_CRC];
    assign frm_pad  = ctl_q.stat[STAT_PAD] && (frm_len < LEN_W'(MIN_FRAME));

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_req && !frm_ack) |=> (frm_req && $stable(frm_len) && $stable(frm_addr)
                                   && $stable(frm_pad) && $stable(frm_crc)));
    // R4
    req_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_req |-> ctl_q.stat[STAT_RDY]);
    // R6
    clr_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_CLR) |-> ($past(ctl_q.st) == ST_WB || $past(ctl_q.st) == ST_CLR));
    // R8
    src_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_txf && set_txe));
    // R10
    idle_len0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_POLL && ring_len == '0) |=> !frm_req);
endmodule

// File: rtl/eth_txring.sv
module eth_txring
    import eth_txring_pkg::*;
#(
    parameter int DESC_NUM  = 128,
    parameter int ADDR_W    = 12,
    parameter int LEN_W     = 16,
    parameter int MIN_FRAME = 64,
    localparam int IDX_W    = $clog2(DESC_NUM),
    localparam int WI_W     = IDX_W + 1,
    localparam int CNT_W    = $clog2(DESC_NUM + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              irq,
    output logic              frm_req,
    input  logic              frm_ack,
    output logic [LEN_W-1:0]  frm_len,
    output logic [31:0]       frm_addr,
    output logic              frm_pad,
    output logic              frm_crc,
    input  logic              done_vld,
    input  logic [8:0]        done_stat
);
    logic             ram_we_h, eng_we, set_txf, set_txe;
    logic [WI_W-1:0]  ram_idx_h, eng_widx;
    logic [31:0]      ram_rdata_h, eng_wdata, cur_stat, cur_addr;
    logic [IDX_W-1:0] desc_idx;
    logic [CNT_W-1:0] ring_len;

    txring_regs #(.DESC_NUM(DESC_NUM), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ram_rdata(ram_rdata_h), .ram_we(ram_we_h), .ram_idx(ram_idx_h),
        .set_txf(set_txf), .set_txe(set_txe),
        .ring_len(ring_len), .irq(irq)
    );

    txring_desc_ram #(.DESC_NUM(DESC_NUM)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .host_we(ram_we_h), .host_idx(ram_idx_h), .host_wdata(host_wdata),
        .host_rdata(ram_rdata_h),
        .eng_we(eng_we), .eng_widx(eng_widx), .eng_wdata(eng_wdata),
        .eng_desc(desc_idx), .eng_stat(cur_stat), .eng_addr(cur_addr)
    );

    txring_ctrl #(.DESC_NUM(DESC_NUM), .LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ring_len(ring_len), .host_ram_we(ram_we_h),
        .cur_stat(cur_stat), .cur_addr(cur_addr),
        .desc_idx(desc_idx),
        .eng_we(eng_we), .eng_widx(eng_widx), .eng_wdata(eng_wdata),
        .frm_req(frm_req), .frm_ack(frm_ack), .frm_len(frm_len),
        .frm_addr(frm_addr), .frm_pad(frm_pad), .frm_crc(frm_crc),
        .done_vld(done_vld), .done_stat(done_stat),
        .set_txf(set_txf), .set_txe(set_txe)
    );
endmodule

// File: tb/test_eth_txring.sv
module test_eth_txring;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0, host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq, frm_req, frm_pad, frm_crc;
    logic        frm_ack = 1'b0, done_vld = 1'b0;
    logic [15:0] frm_len;
    logic [31:0] frm_addr;
    logic [8:0]  done_stat = '0;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    localparam int RING = 5;

    always #2 clk = ~clk;

    eth_txring i_eth_txring (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
        .frm_req(frm_req), .frm_ack(frm_ack), .frm_len(frm_len),
        .frm_addr(frm_addr), .frm_pad(frm_pad), .frm_crc(frm_crc),
        .done_vld(done_vld), .done_stat(done_stat)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        host_sel = 1; host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 0; host_we = 0;
    endtask

    task automatic hrd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        host_sel = 1; host_we = 0; host_addr = a;
        @(negedge clk);
        host_sel = 0;
        d = host_rdata;
    endtask

    function automatic logic [31:0] exp_wb(input logic [31:0] s, input logic [8:0] r);
        return {s[31:16], 1'b0, s[14:9], r};
    endfunction

    function automatic logic [1:0] exp_src(input logic [31:0] s, input logic [8:0] r);
        if (!s[14]) return 2'b00;
        return (|(r & 9'h10D)) ? 2'b10 : 2'b01;
    endfunction

    function automatic bit exp_pad(input logic [31:0] s);
        return s[12] && (s[31:16] < 16'd64);
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        logic [31:0] rd, st;
        logic [8:0]  res;
        logic [1:0]  src;
        int idx;
        bit seen, hold_ok;
        void'($urandom(32'h5eed_1234));

        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        hrd(12'h004, rd); check(rd == 0, "R1 src", rd, 0);
        hrd(12'h008, rd); check(rd == 0, "R1 mask", rd, 0);
        hrd(12'h020, rd); check(rd == 0, "R1 len", rd, 0);

        // R10 zero ring length: ready descriptor is ignored
        hwr(12'h400, 32'h0064_8000);
        seen = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (frm_req) seen = 1; end
        check(!seen, "R10 no request at len 0", seen, 0);
        hwr(12'h400, 32'h0);

        // R2 cap
        hwr(12'h020, 32'h95); hrd(12'h020, rd); check(rd == 32'h80, "R2 cap", rd, 32'h80);
        hwr(12'h020, 32'h80); hrd(12'h020, rd); check(rd == 32'h80, "R2 at cap", rd, 32'h80);
        hwr(12'h020, RING);   hrd(12'h020, rd); check(rd == RING, "R2 store", rd, RING);

        // R9 mask
        hwr(12'h008, 32'h3); hrd(12'h008, rd); check(rd == 3, "R9 mask", rd, 3);

        // R3 address words
        for (int i = 0; i < RING; i++) hwr(12'(12'h404 + 8 * i), 32'h1000_0000 + 32'(i) * 32'h600);
        hrd(12'h40C, rd); check(rd == 32'h1000_0600, "R3 addr word", rd, 32'h1000_0600);

        idx = 0;
        for (int k = 0; k < 30; k++) begin
            st = $urandom;
            st[31:16] = (k % 4 == 0) ? 16'($urandom_range(20, 63)) : 16'($urandom_range(64, 1500));
            st[15] = 1'b1;
            st[14] = (k % 5 != 3);
            st[13] = (k % 7 == 6);

            if (k == 2) begin
                // R4 not ready: engine keeps polling, no request
                hwr(12'(12'h400 + 8 * idx), st & ~32'h8000);
                seen = 0;
                for (int i = 0; i < 15; i++) begin @(negedge clk); if (frm_req) seen = 1; end
                check(!seen, "R4 not ready polled", seen, 0);
            end
            hwr(12'(12'h400 + 8 * idx), st);

            seen = 0;
            for (int i = 0; i < 200; i++) begin
                if (frm_req) begin seen = 1; break; end
                @(negedge clk);
            end
            check(seen, "R4 request issued", seen, 1);
            check(frm_addr == 32'h1000_0000 + 32'(idx) * 32'h600, "R7 order/addr",
                  frm_addr, 32'h1000_0000 + 32'(idx) * 32'h600);
            check(frm_len == st[31:16], "R5 len", frm_len, st[31:16]);
            check(frm_pad == exp_pad(st), "R5 pad", frm_pad, exp_pad(st));
            check(frm_crc == st[11], "R5 crc", frm_crc, st[11]);

            hold_ok = 1;
            for (int i = 0; i < int'($urandom_range(0, 3)); i++) begin
                @(negedge clk);
                if (!frm_req || frm_len != st[31:16]) hold_ok = 0;
            end
            check(hold_ok, "R5 hold until ack", hold_ok, 1);
            frm_ack = 1; @(negedge clk); frm_ack = 0;

            res = 9'($urandom);
            if (k % 3 == 0) res = res & ~9'h10D;
            repeat ($urandom_range(1, 3)) @(negedge clk);
            done_vld = 1; done_stat = res; @(negedge clk); done_vld = 0;
            repeat (3) @(negedge clk);

            hrd(12'(12'h400 + 8 * idx), rd);
            check(rd == exp_wb(st, res), "R6 write-back", rd, exp_wb(st, res));
            src = exp_src(st, res);
            hrd(12'h004, rd);
            check(rd == 32'(src), "R8 source", rd, src);
            check(irq == (src != 0), "R9 irq", irq, src != 0);
            if (k == 5 || k == 1) begin
                hwr(12'h008, 32'h0);
                check(irq == 0, "R9 masked", irq, 0);
                hwr(12'h008, 32'h3);
            end
            hwr(12'h004, 32'h3);
            hrd(12'h004, rd); check(rd == 0, "R8 clear", rd, 0);

            idx = (st[13] || idx == RING - 1) ? 0 : idx + 1;
        end

        finished = 1;
        summary();
    end
endmodule